// File: doc/BRIEF.md
# Data memory space decoder

This block sits beside an 8051-class core and steers every data memory access to exactly one target. The four on-chip targets are lower RAM, upper RAM, the special function register space and a 256-byte expanded RAM. The fifth target is the external bus. Upper RAM and the register space occupy the same addresses, 80H to FFH, so the access type alone decides between them. MOVX transfers can be kept on chip, in which case they produce no external bus activity. An auxiliary control register, held inside the block, selects whether MOVX stays on chip and whether ALE runs freely.

Decoding is purely combinational from the access inputs and the register. For accesses that leave the chip, the block also drives the external read and write strobe enables and the override enables for the Port 0 and Port 2 buses. The ALE output either pulses freely at a fixed divide of the clock or is gated so that it appears only during external accesses.

Top module: `dmem_decoder`

## Requirements
- R1: For access types direct (code 0), indirect (code 1) and stack (code 2), an address whose low byte is 00H to 7FH asserts `sel_lo_o` only. Address bits above bit 7 are ignored for these types.
- R2: For a low byte of 80H to FFH, a direct access asserts `sel_sfr_o` and an indirect access asserts `sel_up_o`.
- R3: A stack access (code 2) never selects expanded RAM or the external bus. At 80H to FFH it asserts `sel_up_o`.
- R4: When the on-chip-MOVX bit is 0, MOVX @Ri (code 3) at any address, and MOVX @DPTR (code 4) with address bits 15..8 equal to zero, assert `sel_eram_o`. They keep `ext_rd_o`, `ext_wr_o`, `p0_bus_o` and `p2_bus_o` low.
- R5: When the on-chip-MOVX bit is 0, MOVX @DPTR with address 0100H or above asserts `sel_ext_o`, `p0_bus_o` and `p2_bus_o`, with `ext_rd_o` equal to `rd_i` and `ext_wr_o` equal to `wr_i`.
- R6: When the on-chip-MOVX bit is 1, every MOVX asserts `sel_ext_o` with strobes that follow `rd_i` and `wr_i`. The @Ri form asserts `p0_bus_o` only. The @DPTR form asserts both `p0_bus_o` and `p2_bus_o`.
- R7: The auxiliary register has bit 0 = ALE-off, bit 1 = on-chip-MOVX disable (external), and bit 2 = converter low-voltage enable, which drives `lvadc_o`. It resets to 3'b110 and loads `aux_wdata_i` on a clock edge with `aux_we_i` high.
- R8: With ALE-off = 0, `ale_o` is high for one cycle out of every `ALE_DIV` (default 6), continuously. With ALE-off = 1, `ale_o` pulses only while `sel_ext_o` is high.
- R9: When `rd_i` or `wr_i` is high and the type is 0 to 5, exactly one select is high. When both strobes are low, or the type is 6 or 7, no select, strobe or override is high.
- R10: A code read (type 5) asserts `sel_ext_o`, `p0_bus_o` and `p2_bus_o` but keeps `ext_rd_o` and `ext_wr_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Access type code |
| addr_i | input | ADDR_W | Access address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| aux_we_i | input | 1 | Auxiliary register write enable |
| aux_wdata_i | input | 3 | Auxiliary register write data |
| sel_lo_o | output | 1 | Lower RAM select |
| sel_up_o | output | 1 | Upper RAM select |
| sel_sfr_o | output | 1 | Register space select |
| sel_eram_o | output | 1 | Expanded RAM select |
| sel_ext_o | output | 1 | External bus select |
| ext_rd_o | output | 1 | External read strobe enable |
| ext_wr_o | output | 1 | External write strobe enable |
| p0_bus_o | output | 1 | Port 0 bus override enable |
| p2_bus_o | output | 1 | Port 2 address override enable |
| ale_en_o | output | 1 | ALE gate |
| ale_o | output | 1 | ALE pulse |
| lvadc_o | output | 1 | Converter low-voltage enable |

## Verification
The bench sweeps every low address byte against all eight type codes, three page values, both on-chip-MOVX settings and the idle, read and write strobes. This sweep catches several distinct faults:
- A decoder that keys upper RAM against the register space on the address instead of the type shows up at 80H through FFH.
- A design that sends the stack to expanded RAM shows up on stack accesses.
- A design that checks only the low byte of DPTR shows up on page 01H and FFH accesses, which would wrongly land in expanded RAM.
- Strobes that leak on on-chip MOVX, or on code reads, make the strobe comparison fail.

The ALE pulse count is taken over whole divider windows in both gate modes, so a wrong divide or a gate that ignores the ALE-off bit changes the count.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam logic [2:0] ACC_DIRECT    = 3'd0;
  localparam logic [2:0] ACC_INDIRECT  = 3'd1;
  localparam logic [2:0] ACC_STACK     = 3'd2;
  localparam logic [2:0] ACC_MOVX_RI   = 3'd3;
  localparam logic [2:0] ACC_MOVX_DPTR = 3'd4;
  localparam logic [2:0] ACC_MOVC      = 3'd5;

  typedef struct packed {
    logic lvadc;
    logic extram;
    logic ao;
  } aux_t;

  localparam logic [2:0] AUX_RST = 3'b110;

  typedef struct packed {
    logic lo;
    logic up;
    logic sfr;
    logic eram;
    logic ext;
    logic ext_rd;
    logic ext_wr;
    logic p0_bus;
    logic p2_bus;
  } route_t;
endpackage

// File: rtl/dmem_aux_reg.sv
module dmem_aux_reg
  import dmem_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] wdata_i,
  output aux_t       q_o
);
  aux_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= aux_t'(AUX_RST);
    else if (we_i) q <= aux_t'(wdata_i);
  end

  assign q_o = q;
endmodule

// File: rtl/dmem_route.sv
module dmem_route
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              extram_i,
  output route_t            route_o
);
  localparam int unsigned BYTE_W = 8;

  logic   active;
  logic   upper_half;
  logic   page_zero;
  logic   xfer;
  route_t r;

  assign active     = rd_i | wr_i;
  assign upper_half = addr_i[BYTE_W-1];
  assign page_zero  = (addr_i[ADDR_W-1:BYTE_W] == '0);

  always_comb begin
    r = '0;
    if (active) begin
      case (mode_i)
        ACC_DIRECT: begin
          if (upper_half) r.sfr = 1'b1;
          else            r.lo  = 1'b1;
        end
        ACC_INDIRECT, ACC_STACK: begin
          if (upper_half) r.up = 1'b1;
          else            r.lo = 1'b1;
        end
        ACC_MOVX_RI: begin
          if (extram_i) begin
            r.ext    = 1'b1;
            r.p0_bus = 1'b1;
          end else begin
            r.eram = 1'b1;
          end
        end
        ACC_MOVX_DPTR: begin
          if (!extram_i && page_zero) begin
            r.eram = 1'b1;
          end else begin
            r.ext    = 1'b1;
            r.p0_bus = 1'b1;
            r.p2_bus = 1'b1;
          end
        end
        ACC_MOVC: begin
          r.ext    = 1'b1;
          r.p0_bus = 1'b1;
          r.p2_bus = 1'b1;
        end
        default: r = '0;
      endcase
    end
    // code reads use the program strobe, not RD/WR
    xfer     = r.ext && (mode_i != ACC_MOVC);
    r.ext_rd = xfer & rd_i;
    r.ext_wr = xfer & wr_i;
  end

  assign route_o = r;
endmodule

// File: rtl/dmem_ale_gen.sv
module dmem_ale_gen #(
  parameter int unsigned DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic ale_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign tick  = (cnt == LAST);
  assign ale_o = tick & gate_i;
endmodule

// File: rtl/dmem_decoder.sv
module dmem_decoder
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned ALE_DIV = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              aux_we_i,
  input  logic [2:0]        aux_wdata_i,
  output logic              sel_lo_o,
  output logic              sel_up_o,
  output logic              sel_sfr_o,
  output logic              sel_eram_o,
  output logic              sel_ext_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o,
  output logic              p0_bus_o,
  output logic              p2_bus_o,
  output logic              ale_en_o,
  output logic              ale_o,
  output logic              lvadc_o
);
  aux_t   aux_q;
  route_t route;

  dmem_aux_reg u_aux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (aux_we_i),
    .wdata_i (aux_wdata_i),
    .q_o     (aux_q)
  );

  dmem_route #(.ADDR_W(ADDR_W)) u_route (
    .mode_i   (mode_i),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .extram_i (aux_q.extram),
    .route_o  (route)
  );

  assign ale_en_o = ~aux_q.ao | route.ext;

  dmem_ale_gen #(.DIV(ALE_DIV)) u_ale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (ale_en_o),
    .ale_o  (ale_o)
  );

  assign sel_lo_o   = route.lo;
  assign sel_up_o   = route.up;
  assign sel_sfr_o  = route.sfr;
  assign sel_eram_o = route.eram;
  assign sel_ext_o  = route.ext;
  assign ext_rd_o   = route.ext_rd;
  assign ext_wr_o   = route.ext_wr;
  assign p0_bus_o   = route.p0_bus;
  assign p2_bus_o   = route.p2_bus;
  assign lvadc_o    = aux_q.lvadc;
endmodule

// File: rtl/dmem_decoder_chk.sv
module dmem_decoder_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              aux_we_i,
  input logic              sel_lo_o,
  input logic              sel_up_o,
  input logic              sel_sfr_o,
  input logic              sel_eram_o,
  input logic              sel_ext_o,
  input logic              ext_rd_o,
  input logic              ext_wr_o,
  input logic              p0_bus_o,
  input logic              p2_bus_o,
  input logic              ale_o,
  input logic              lvadc_o
);
  logic [4:0] sels;
  assign sels = {sel_lo_o, sel_up_o, sel_sfr_o, sel_eram_o, sel_ext_o};

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sels));

  p_valid_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && mode_i <= 3'd5) |-> $countones(sels) == 1);

  p_idle_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |-> (sels == 5'd0 && !ext_rd_o && !ext_wr_o && !p0_bus_o && !p2_bus_o));

  p_eram_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_eram_o |-> (!ext_rd_o && !ext_wr_o && !p0_bus_o && !p2_bus_o));

  p_stack_internal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2) |-> (!sel_eram_o && !sel_ext_o));

  p_sfr_direct_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_sfr_o |-> (mode_i == 3'd0 && addr_i[7]));

  p_strobe_ext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rd_o || ext_wr_o) |-> (sel_ext_o && p0_bus_o && mode_i != 3'd5));

  p_ale_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  p_aux_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_we_i |=> $stable(lvadc_o));
endmodule

bind dmem_decoder dmem_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dmem_decoder_tb.sv
module dmem_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int ALE_DIV = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        mode_i = '0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              rd_i = 1'b0;
  logic              wr_i = 1'b0;
  logic              aux_we_i = 1'b0;
  logic [2:0]        aux_wdata_i = '0;
  logic sel_lo_o, sel_up_o, sel_sfr_o, sel_eram_o, sel_ext_o;
  logic ext_rd_o, ext_wr_o, p0_bus_o, p2_bus_o, ale_en_o, ale_o, lvadc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dmem_decoder #(.ADDR_W(ADDR_W), .ALE_DIV(ALE_DIV)) u_dut (.*);

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // {lo,up,sfr,eram,ext,erd,ewr,p0,p2}
  function automatic logic [8:0] model(bit ext_mode, int m, int a, bit rd, bit wr);
    logic [8:0] e;
    bit lowhalf;
    int page;
    e = '0;
    if (!(rd || wr) || m > 5) return e;
    lowhalf = (a % 256) < 128;
    page = a / 256;
    if (m <= 2) begin
      if (lowhalf) e[8] = 1'b1;
      else if (m == 0) e[6] = 1'b1;
      else e[7] = 1'b1;
    end else if (m == 3) begin
      if (ext_mode) begin e[4] = 1'b1; e[1] = 1'b1; end
      else e[5] = 1'b1;
    end else if (m == 4) begin
      if (ext_mode || page != 0) begin e[4] = 1'b1; e[1] = 1'b1; e[0] = 1'b1; end
      else e[5] = 1'b1;
    end else begin
      e[4] = 1'b1; e[1] = 1'b1; e[0] = 1'b1;
    end
    if (e[4] && m != 5) begin e[3] = rd; e[2] = wr; end
    return e;
  endfunction

  function automatic string tag_of(bit ext_mode, int m, int a, bit rd, bit wr);
    if (!(rd || wr) || m > 5) return "R9";
    if (m <= 2 && (a % 256) < 128) return "R1";
    if (m == 2) return "R3";
    if (m <= 1) return "R2";
    if (m == 5) return "R10";
    if (ext_mode) return "R6";
    if (m == 4 && a / 256 != 0) return "R5";
    return "R4";
  endfunction

  task automatic set_aux(input logic [2:0] v);
    @(negedge clk_i);
    aux_we_i = 1'b1;
    aux_wdata_i = v;
    @(negedge clk_i);
    aux_we_i = 1'b0;
  endtask

  task automatic count_ale(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (ale_o) cnt++;
    end
  endtask

  function automatic logic [8:0] outs();
    return {sel_lo_o, sel_up_o, sel_sfr_o, sel_eram_o, sel_ext_o,
            ext_rd_o, ext_wr_o, p0_bus_o, p2_bus_o};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int pages[3];
    pages[0] = 0; pages[1] = 1; pages[2] = 255;

    // reset state
    #(CLK_PERIOD * 2 + 1);
    chk("R7 reset lvadc", lvadc_o, 1);
    chk("R9 reset idle", outs(), 0);
    chk("R8 reset ale", ale_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // default on-chip-MOVX bit = 1 -> external
    @(negedge clk_i);
    mode_i = 3'd3; addr_i = 16'h0010; rd_i = 1'b1;
    #1;
    chk("R7 reset extram ext", sel_ext_o, 1);
    rd_i = 1'b0;

    // R8 free-running ALE with ao=0
    count_ale(ALE_DIV * 6, n);
    chk("R8 free ale count", n, 6);

    // R7 write lvadc=0, extram=0, ao=0
    set_aux(3'b000);
    chk("R7 lvadc write", lvadc_o, 0);
    mode_i = 3'd3; addr_i = 16'h0010; rd_i = 1'b1;
    #1;
    chk("R7 extram write eram", sel_eram_o, 1);
    rd_i = 1'b0;

    // R8 gated: ao=1 idle -> no ALE
    set_aux(3'b001);
    count_ale(ALE_DIV * 6, n);
    chk("R8 gated idle ale", n, 0);
    mode_i = 3'd3; addr_i = 16'h00A0; rd_i = 1'b1;
    count_ale(ALE_DIV * 6, n);
    chk("R8 gated eram ale", n, 0);
    mode_i = 3'd4; addr_i = 16'h1234; rd_i = 1'b1;
    count_ale(ALE_DIV * 6, n);
    chk("R8 gated ext ale", n, 6);
    chk("R8 ale_en ext", ale_en_o, 1);
    rd_i = 1'b0;
    #1;
    chk("R8 ale_en idle", ale_en_o, 0);

    // exhaustive decode sweep
    for (int x = 0; x < 2; x++) begin
      set_aux({1'b1, x[0], 1'b0});
      for (int m = 0; m < 8; m++)
        for (int p = 0; p < 3; p++)
          for (int lo = 0; lo < 256; lo++)
            for (int s = 0; s < 3; s++) begin
              logic [8:0] e;
              bit r, w;
              int a;
              r = (s == 1);
              w = (s == 2);
              a = pages[p] * 256 + lo;
              @(negedge clk_i);
              mode_i = m[2:0]; addr_i = a[15:0]; rd_i = r; wr_i = w;
              #1;
              e = model(x[0], m, a, r, w);
              checks++;
              if (outs() != e) begin
                errors++;
                $display("FAIL %s ext=%0d mode=%0d addr=%h got=%b exp=%b",
                         tag_of(x[0], m, a, r, w), x, m, a, outs(), e);
              end
            end
    end
    rd_i = 1'b0; wr_i = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule